// File: doc/BRIEF.md
# DLL Phase Decision Controller

This block is the digital decision stage of a delay-locked loop. Once per reference clock cycle it receives two sample bits, already synchronized to that clock. `fb_lead_i` is high when the feedback clock's rising edge arrived before the reference rising edge. `fb_lead_dly_i` is high when a copy of the feedback, delayed by one unit delay element, also arrived before that edge. From this pair the block decides whether the delay chain needs one more unit of delay, one less, or none. It issues one-cycle step commands that go to the tap-select shift register, and it reports lock.

Decisions are paced by a divide-by-two. Only every other reference cycle's sample pair is evaluated, so the delay chain has time to settle after a move before it is judged again. An optional filter mode suppresses single noisy results: a command is issued only when four consecutive evaluated decisions agree on a direction. A separate step-enable output lets the shift register run its clock only while a command is pending, so the register stays idle while the loop is locked.

Top module: `dll_phase_ctrl`

## Requirements
- R1: At an evaluation, the pair lead=1, lead_dly=1 means the feedback is early beyond the window. In unfiltered mode this raises `add_dly_o` for one cycle after that evaluation edge.
- R2: At an evaluation, the pair lead=0, lead_dly=0 means the feedback is late. In unfiltered mode this raises `cut_dly_o` for one cycle after that evaluation edge.
- R3: At an evaluation, the pair lead=1, lead_dly=0 means the reference edge lies inside the one-unit window. It sets `locked_o` and issues no command. Whenever `locked_o` is high, both commands are low.
- R4: At an evaluation, the inconsistent pair lead=0, lead_dly=1 issues no command, clears `locked_o` and ends any filter run.
- R5: The first evaluation uses the inputs present at the second rising edge after reset is released. Later evaluations occur on every second edge. Inputs present at the other edges have no effect on any output.
- R6: `add_dly_o` and `cut_dly_o` are never high together, and each stays high for exactly one cycle.
- R7: `chain_step_o` is high exactly in the cycles in which `add_dly_o` or `cut_dly_o` is high.
- R8: With `filter_en_i` high, a command is issued only on the fourth consecutive evaluation that gives the same direction. The run count then restarts from zero, so a steady direction yields one command per four evaluations.
- R9: With the filter on, a run restarts whenever the evaluated direction changes, a lock or inconsistent pair is evaluated, or the filter is off during an evaluation.
- R10: A synchronous active-high `rst` clears the pacing divider, the filter run and all outputs. All outputs read low in the cycle after reset.
- R11: `locked_o` changes only at evaluation edges and holds its value between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_lead_i | input | 1 | Feedback edge came before the reference rising edge |
| fb_lead_dly_i | input | 1 | Unit-delayed feedback edge came before the reference rising edge |
| filter_en_i | input | 1 | Require four agreeing decisions before a command |
| add_dly_o | output | 1 | One-cycle request for one more unit of delay |
| cut_dly_o | output | 1 | One-cycle request for one less unit of delay |
| locked_o | output | 1 | Reference edge is inside the one-unit window |
| chain_step_o | output | 1 | Step enable for the tap-select shift register |

## Verification
The hardest situation to reach is a filter run that is broken on its last step: three agreeing decisions followed by a reversal, a lock or a reset. These must be placed exactly on evaluation edges, because samples between them are ignored. The stimulus holds each sample pair for whole two-cycle slots in scripted runs of three, four and five agreeing decisions with interrupting pairs between them. It also toggles the inputs every cycle, so that values on the off-phase edges would show up if they leaked in. A long pseudo-random run with filter toggling is then compared against the behavioural model on every clock.

// File: rtl/dll_dec_pkg.sv
package dll_dec_pkg;
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_LOCK = 2'd1,
    DEC_MORE = 2'd2,
    DEC_LESS = 2'd3
  } dec_e;
endpackage

// File: rtl/dll_pace_div.sv
module dll_pace_div #(
  parameter int PACE = 2
) (
  input  logic clk,
  input  logic rst,
  output logic eval_o
);
  localparam int W = (PACE > 1) ? $clog2(PACE) : 1;
  localparam logic [W-1:0] LAST = W'(PACE - 1);

  logic [W-1:0] phase_q;

  assign eval_o = (phase_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         phase_q <= '0;
    else if (eval_o) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  generate
    if (PACE >= 2) begin : g_space_chk
      // R5
      eval_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        eval_o |=> !eval_o);
    end
  endgenerate
endmodule

// File: rtl/dll_phase_classify.sv
module dll_phase_classify
  import dll_dec_pkg::*;
(
  input  logic lead_i,
  input  logic lead_dly_i,
  output dec_e dec_o
);
  always_comb begin
    unique case ({lead_i, lead_dly_i})
      2'b11:   dec_o = DEC_MORE;
      2'b00:   dec_o = DEC_LESS;
      2'b10:   dec_o = DEC_LOCK;
      default: dec_o = DEC_NONE;
    endcase
  end
endmodule

// File: rtl/dll_run_filter.sv
module dll_run_filter
  import dll_dec_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic eval_i,
  input  dec_e dec_i,
  input  logic filt_en_i,
  output logic more_o,
  output logic less_o
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FIRE_AT = CW'(RUN_LEN - 1);

  logic [CW-1:0] run_q;
  dec_e          last_q;
  logic          directional;
  logic          same_run;
  logic          fire;

  assign directional = (dec_i == DEC_MORE) || (dec_i == DEC_LESS);
  assign same_run    = (run_q != '0) && (dec_i == last_q);
  assign fire        = eval_i && directional &&
                       (!filt_en_i || (same_run && run_q == FIRE_AT));
  assign more_o      = fire && (dec_i == DEC_MORE);
  assign less_o      = fire && (dec_i == DEC_LESS);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      last_q <= DEC_NONE;
    end else if (eval_i) begin
      if (!directional || !filt_en_i || fire) begin
        run_q <= '0;
      end else if (same_run) begin
        run_q <= run_q + 1'b1;
      end else begin
        run_q  <= CW'(1);
        last_q <= dec_i;
      end
    end
  end

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q < CW'(RUN_LEN));

  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> $stable(run_q));
endmodule

// File: rtl/dll_phase_ctrl.sv
module dll_phase_ctrl
  import dll_dec_pkg::*;
#(
  parameter int PACE    = 2,
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic fb_lead_i,
  input  logic fb_lead_dly_i,
  input  logic filter_en_i,
  output logic add_dly_o,
  output logic cut_dly_o,
  output logic locked_o,
  output logic chain_step_o
);
  logic eval;
  dec_e dec;
  logic fire_more;
  logic fire_less;

  dll_pace_div #(.PACE(PACE)) u_pace (
    .clk    (clk),
    .rst    (rst),
    .eval_o (eval)
  );

  dll_phase_classify u_cls (
    .lead_i     (fb_lead_i),
    .lead_dly_i (fb_lead_dly_i),
    .dec_o      (dec)
  );

  dll_run_filter #(.RUN_LEN(RUN_LEN)) u_filt (
    .clk       (clk),
    .rst       (rst),
    .eval_i    (eval),
    .dec_i     (dec),
    .filt_en_i (filter_en_i),
    .more_o    (fire_more),
    .less_o    (fire_less)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      add_dly_o    <= 1'b0;
      cut_dly_o    <= 1'b0;
      locked_o     <= 1'b0;
      chain_step_o <= 1'b0;
    end else begin
      add_dly_o    <= fire_more;
      cut_dly_o    <= fire_less;
      chain_step_o <= fire_more | fire_less;
      if (eval) locked_o <= (dec == DEC_LOCK);
    end
  end

  // R6
  cmd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(add_dly_o && cut_dly_o));

  // R6
  add_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    add_dly_o |=> !add_dly_o);

  // R6
  cut_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cut_dly_o |=> !cut_dly_o);

  // R3
  lock_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    locked_o |-> !(add_dly_o || cut_dly_o));

  // R11
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(locked_o));
endmodule

// File: tb/dll_phase_ctrl_bench.sv
module dll_phase_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lead = 1'b0;
  logic lead_dly = 1'b0;
  logic filt = 1'b0;
  logic add_o, cut_o, lock_o, step_o;

  always #5 clk = ~clk;

  dll_phase_ctrl u_dll_phase_ctrl (
    .clk           (clk),
    .rst           (rst),
    .fb_lead_i     (lead),
    .fb_lead_dly_i (lead_dly),
    .filter_en_i   (filter_en_i_w),
    .add_dly_o     (add_o),
    .cut_dly_o     (cut_o),
    .locked_o      (lock_o),
    .chain_step_o  (step_o)
  );
  wire filter_en_i_w = filt;

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R10";
  bit    done   = 0;

  // behavioural reference: 0 none, 1 lock, 2 more, 3 less
  int ph = 0, run = 0, last = 0;
  bit e_add = 0, e_cut = 0, e_lock = 0;

  function automatic int classify(bit a, bit b);
    if (a && b)   return 2;
    if (!a && !b) return 3;
    if (a && !b)  return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    int d;
    bit fire;
    if (rst) begin
      ph = 0; run = 0; last = 0;
      e_add = 0; e_cut = 0; e_lock = 0;
    end else begin
      e_add = 0; e_cut = 0; fire = 0;
      if (ph == 1) begin
        d = classify(lead, lead_dly);
        e_lock = (d == 1);
        if (d >= 2) begin
          if (!filt) fire = 1;
          else if (run > 0 && d == last) begin
            run++;
            if (run == 4) begin fire = 1; run = 0; end
          end else begin
            run = 1; last = d;
          end
          if (!filt) run = 0;
          e_add = fire && (d == 2);
          e_cut = fire && (d == 3);
        end else begin
          run = 0;
        end
      end
      ph = 1 - ph;
    end
  end

  task automatic cmp(string sig, bit act, bit exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) %s actual=%0b expected=%0b at %0t", req, tag, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cmp("add_dly_o", add_o, e_add, "R1");
      cmp("cut_dly_o", cut_o, e_cut, "R2");
      cmp("locked_o", lock_o, e_lock, "R3");
      cmp("chain_step_o", step_o, e_add | e_cut, "R7");
      cmp("exclusive", add_o & cut_o, 1'b0, "R6");
    end
  end

  task automatic drive(bit a, bit b, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lead = a; lead_dly = b;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit [15:0] lf;
    lf = 16'hACE1;
    repeat (3) @(negedge clk);
    tag = "R10"; rst = 0;
    drive(1, 0, 2);
    tag = "R1";  drive(1, 1, 12);
    tag = "R2";  drive(0, 0, 12);
    tag = "R3";  drive(1, 0, 12);
    tag = "R11"; drive(1, 1, 3); drive(1, 0, 5);
    tag = "R4";  drive(0, 1, 12);
    tag = "R5";
    for (int i = 0; i < 16; i++) begin
      drive(1, 1, 1); drive(0, 0, 1);
    end
    for (int i = 0; i < 16; i++) begin
      drive(1, 0, 1); drive(0, 1, 1);
    end
    tag = "R8"; filt = 1;
    drive(1, 1, 24); drive(0, 0, 24);
    tag = "R9";
    drive(1, 1, 6); drive(0, 0, 2); drive(1, 1, 8);
    drive(1, 1, 6); drive(1, 0, 2); drive(1, 1, 8);
    drive(0, 0, 6); drive(0, 1, 2); drive(0, 0, 10);
    filt = 0; drive(1, 1, 2); filt = 1; drive(1, 1, 8);
    tag = "R10";
    drive(1, 1, 6);
    @(negedge clk); rst = 1;
    drive(1, 1, 2);
    rst = 0;
    drive(1, 1, 10);
    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      lead = lf[0]; lead_dly = lf[0] ? lf[1] & lf[2] : lf[3] & lf[4] & lf[5];
      if (lf[11:4] == 8'h5A) filt = ~filt;
    end
    drive(1, 0, 4);
    finish_run();
  end
endmodule